// File: doc/BRIEF.md
# Indexed Decoder Register Port

This block is the host-side window into the internal registers of a disc sector decoder. The host does not address each register directly. It first loads a register index through an index-write strobe. It then reads or writes a single data port. After each data access the index moves on by itself, so a run of registers can be reached with one index load and a series of data strobes.

The advance is not a plain increment. Index 0 is a dead slot that never moves. Some registers force the index to a fixed value. Writing the reset slot clears the decoder registers and parks the index on the first unmapped slot. Reading the last status byte also parks the index there.

The port holds:
- the interface control register,
- the active-low interface status register,
- a 12-bit data byte counter,
- eleven write-only decoder configuration bytes.

It drives the pending-interrupt flags that the transfer logic consumes. The status bytes produced by the decoder core are taken in as an input and only read back.

Top module: `cdc_regport`

## Requirements
- R1: After reset the index is 0, the status register reads 0xFF, and the control register, byte counter and configuration bytes are 0. Read data is 0xFF and no interrupt is pending.
- R2: An index write loads the low 5 bits of the host data into the index, in the following cycle.
- R3: At index 0, a data write changes no register and a data read returns 0xFF. In both cases the index stays at 0.
- R4: A read at index 1 returns the interface status register and sets the index to 2. Status bit 0 is cleared by a decoder event pulse, and bit 1 by a transfer-end pulse. Clear means pending, because the bits are active low.
- R5: A write at index 2 loads the low byte of the byte counter. A write at index 3 loads only host bits 3:0 into counter bits 11:8 and sets the index to 4. Reads at 2 and 3 return the low byte and {4'hF, counter bits 11:8}.
- R6: A write at index 0x0F does the following:
  - returns the control register, byte counter and configuration bytes to 0;
  - returns the status register to 0xFF;
  - sets the index to 0x10.
- R7: Reads at 0x0C..0x0F return bytes 0..3 of the decoder status input, each byte DATA_W bits wide. A read at 0x0F sets the index to 0x10; the others advance it by one.
- R8: A read at any index without a readable register returns 0xFF. This covers index 4..0x0B and index 0x10..0x1F. Such a read, and any write without a special rule, advances the index by one modulo 32, so 0x1F goes to 0.
- R9: A write at index 0x0A with bit 7 (decode enable) clear sets status bit 0 to 1, meaning not pending. With bit 7 set, status bit 0 is left unchanged.
- R10: Read data is registered. It is valid in the cycle after the read strobe and holds its value while no read is made.
- R11: A write at index 1 loads the control register. A write at index 4+k, for k = 0..10, loads configuration slot k, which is cfg_regs bits 8k+7:8k. The pending flags are irq_pend[i] = ~status[i] & control[i] for i = 0, 1.
- R12: When strobes coincide, an index write wins over a data write, and a data write wins over a read. A decode-disable write wins over a decoder event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx_we | input | 1 | Load index from host_wdata |
| dat_we | input | 1 | Write host_wdata to the indexed register |
| dat_re | input | 1 | Read the indexed register |
| host_wdata | input | 8 | Host write data |
| dec_status | input | 32 | Decoder status bytes, byte k read at index 0x0C+k |
| ev_decode | input | 1 | Decoder event pulse, makes status bit 0 pending |
| ev_xfer_end | input | 1 | Transfer-end pulse, makes status bit 1 pending |
| rdata | output | 8 | Registered read data |
| cur_idx | output | 5 | Current register index |
| ifctl | output | 8 | Interface control register |
| ifsts | output | 8 | Interface status register, active low |
| byte_cnt | output | 12 | Data byte counter |
| cfg_regs | output | 88 | Configuration bytes for index 4..0x0E |
| irq_pend | output | 2 | Enabled pending interrupts |

## Verification
A wrong next-index decision shows on cur_idx one cycle after the strobe. It also puts a later read or write on the wrong register, so the error spreads into every following access of the run. A wrong register update is visible at once on ifctl, ifsts, byte_cnt or cfg_regs. A wrong read selection appears on rdata in the cycle after the read strobe. The bench therefore compares the index after every single access rather than only at the end of a sequence.

// File: rtl/cdc_regport_pkg.sv
package cdc_regport_pkg;
   localparam int IDX_NONE       = 0;
   localparam int IDX_IFSTS      = 1;
   localparam int IDX_CNT_LO     = 2;
   localparam int IDX_CNT_HI     = 3;
   localparam int IDX_CFG_FIRST  = 4;
   localparam int CFG_N          = 11;
   localparam int IDX_DEC_CTRL   = 10;
   localparam int IDX_STAT_FIRST = 12;
   localparam int STAT_N         = 4;
   localparam int IDX_RESET      = 15;
   localparam int IDX_PARK       = 16;

   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_IDX  = 2'd1,
      OP_WR   = 2'd2,
      OP_RD   = 2'd3
   } host_op_e;
endpackage

// File: rtl/cdc_idx_seq.sv
module cdc_idx_seq
   import cdc_regport_pkg::*;
#(
   parameter int IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  host_op_e         op,
   input  logic [IDX_W-1:0] idx_load,
   output logic [IDX_W-1:0] cur_idx
);
   logic [IDX_W-1:0] nxt_idx;
   logic [IDX_W-1:0] inc_idx;

   assign inc_idx = cur_idx + IDX_W'(1);

   always_comb begin
      nxt_idx = cur_idx;
      unique case (op)
         OP_IDX: nxt_idx = idx_load;
         OP_WR: begin
            if (cur_idx == IDX_W'(IDX_NONE))
               nxt_idx = cur_idx;
            else if (cur_idx == IDX_W'(IDX_CNT_HI))
               nxt_idx = IDX_W'(IDX_CFG_FIRST);
            else if (cur_idx == IDX_W'(IDX_RESET))
               nxt_idx = IDX_W'(IDX_PARK);
            else
               nxt_idx = inc_idx;
         end
         OP_RD: begin
            if (cur_idx == IDX_W'(IDX_NONE))
               nxt_idx = cur_idx;
            else if (cur_idx == IDX_W'(IDX_IFSTS))
               nxt_idx = IDX_W'(IDX_CNT_LO);
            else if (cur_idx == IDX_W'(IDX_STAT_FIRST + STAT_N - 1))
               nxt_idx = IDX_W'(IDX_PARK);
            else
               nxt_idx = inc_idx;
         end
         default: nxt_idx = cur_idx;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cur_idx <= '0;
      else
         cur_idx <= nxt_idx;
   end
endmodule

// File: rtl/cdc_reg_bank.sv
module cdc_reg_bank
   import cdc_regport_pkg::*;
#(
   parameter int IDX_W     = 5,
   parameter int DATA_W    = 8,
   parameter int CNT_W     = 12,
   parameter int DECEN_BIT = 7
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  host_op_e                 op,
   input  logic [IDX_W-1:0]         cur_idx,
   input  logic [DATA_W-1:0]        wdata,
   input  logic                     ev_decode,
   input  logic                     ev_xfer_end,
   output logic [DATA_W-1:0]        ifctl,
   output logic [DATA_W-1:0]        ifsts,
   output logic [CNT_W-1:0]         byte_cnt,
   output logic [CFG_N*DATA_W-1:0]  cfg_flat
);
   localparam int HI_W = CNT_W - DATA_W;

   logic wr_op;
   logic soft_rst;
   logic dec_off_wr;

   assign wr_op      = (op == OP_WR);
   assign soft_rst   = wr_op && (cur_idx == IDX_W'(IDX_RESET));
   assign dec_off_wr = wr_op && (cur_idx == IDX_W'(IDX_DEC_CTRL)) && !wdata[DECEN_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ifctl <= '0;
      else if (soft_rst)
         ifctl <= '0;
      else if (wr_op && cur_idx == IDX_W'(IDX_IFSTS))
         ifctl <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ifsts <= '1;
      end else if (soft_rst) begin
         ifsts <= '1;
      end else begin
         if (ev_decode)
            ifsts[0] <= 1'b0;
         if (ev_xfer_end)
            ifsts[1] <= 1'b0;
         if (dec_off_wr)
            ifsts[0] <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_cnt <= '0;
      end else if (soft_rst) begin
         byte_cnt <= '0;
      end else if (wr_op && cur_idx == IDX_W'(IDX_CNT_LO)) begin
         byte_cnt[DATA_W-1:0] <= wdata;
      end else if (wr_op && cur_idx == IDX_W'(IDX_CNT_HI)) begin
         byte_cnt[CNT_W-1:DATA_W] <= wdata[HI_W-1:0];
      end
   end

   for (genvar k = 0; k < CFG_N; k++) begin : g_cfg
      logic [DATA_W-1:0] cfg_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cfg_q <= '0;
         else if (soft_rst)
            cfg_q <= '0;
         else if (wr_op && cur_idx == IDX_W'(IDX_CFG_FIRST + k))
            cfg_q <= wdata;
      end
      assign cfg_flat[k*DATA_W +: DATA_W] = cfg_q;
   end
endmodule

// File: rtl/cdc_read_mux.sv
module cdc_read_mux
   import cdc_regport_pkg::*;
#(
   parameter int IDX_W        = 5,
   parameter int DATA_W       = 8,
   parameter int CNT_W        = 12,
   parameter bit HI_FILL_ONES = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  host_op_e                  op,
   input  logic [IDX_W-1:0]          cur_idx,
   input  logic [DATA_W-1:0]         ifsts,
   input  logic [CNT_W-1:0]          byte_cnt,
   input  logic [STAT_N*DATA_W-1:0]  dec_status,
   output logic [DATA_W-1:0]         rdata
);
   localparam int HI_W  = CNT_W - DATA_W;
   localparam int PAD_W = DATA_W - HI_W;

   logic [DATA_W-1:0] cnt_hi_rd;
   logic [DATA_W-1:0] sel;

   if (HI_FILL_ONES) begin : g_fill_one
      assign cnt_hi_rd = {{PAD_W{1'b1}}, byte_cnt[CNT_W-1:DATA_W]};
   end else begin : g_fill_zero
      assign cnt_hi_rd = {{PAD_W{1'b0}}, byte_cnt[CNT_W-1:DATA_W]};
   end

   always_comb begin
      sel = '1;
      if (cur_idx == IDX_W'(IDX_IFSTS))
         sel = ifsts;
      else if (cur_idx == IDX_W'(IDX_CNT_LO))
         sel = byte_cnt[DATA_W-1:0];
      else if (cur_idx == IDX_W'(IDX_CNT_HI))
         sel = cnt_hi_rd;
      for (int k = 0; k < STAT_N; k++) begin
         if (cur_idx == IDX_W'(IDX_STAT_FIRST + k))
            sel = dec_status[k*DATA_W +: DATA_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '1;
      else if (op == OP_RD)
         rdata <= sel;
   end
endmodule

// File: rtl/cdc_regport.sv
module cdc_regport
   import cdc_regport_pkg::*;
#(
   parameter int IDX_W        = 5,
   parameter int DATA_W       = 8,
   parameter int CNT_W        = 12,
   parameter int DECEN_BIT    = 7,
   parameter bit HI_FILL_ONES = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      idx_we,
   input  logic                      dat_we,
   input  logic                      dat_re,
   input  logic [DATA_W-1:0]         host_wdata,
   input  logic [STAT_N*DATA_W-1:0]  dec_status,
   input  logic                      ev_decode,
   input  logic                      ev_xfer_end,
   output logic [DATA_W-1:0]         rdata,
   output logic [IDX_W-1:0]          cur_idx,
   output logic [DATA_W-1:0]         ifctl,
   output logic [DATA_W-1:0]         ifsts,
   output logic [CNT_W-1:0]          byte_cnt,
   output logic [CFG_N*DATA_W-1:0]   cfg_regs,
   output logic [1:0]                irq_pend
);
   if (IDX_W < 5 || IDX_W >= DATA_W) begin : g_bad_idx
      $error("cdc_regport: IDX_W must be at least 5 and below DATA_W");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("cdc_regport: DATA_W must be at least 8");
   end
   if (CNT_W <= DATA_W || CNT_W >= 2*DATA_W) begin : g_bad_cnt
      $error("cdc_regport: CNT_W must lie strictly between DATA_W and 2*DATA_W");
   end
   if (DECEN_BIT >= DATA_W) begin : g_bad_decen
      $error("cdc_regport: DECEN_BIT outside data width");
   end

   host_op_e op;

   always_comb begin
      if (idx_we)
         op = OP_IDX;
      else if (dat_we)
         op = OP_WR;
      else if (dat_re)
         op = OP_RD;
      else
         op = OP_NONE;
   end

   cdc_idx_seq #(.IDX_W(IDX_W)) i_idx_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (op),
      .idx_load (host_wdata[IDX_W-1:0]),
      .cur_idx  (cur_idx)
   );

   cdc_reg_bank #(
      .IDX_W     (IDX_W),
      .DATA_W    (DATA_W),
      .CNT_W     (CNT_W),
      .DECEN_BIT (DECEN_BIT)
   ) i_reg_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .op          (op),
      .cur_idx     (cur_idx),
      .wdata       (host_wdata),
      .ev_decode   (ev_decode),
      .ev_xfer_end (ev_xfer_end),
      .ifctl       (ifctl),
      .ifsts       (ifsts),
      .byte_cnt    (byte_cnt),
      .cfg_flat    (cfg_regs)
   );

   cdc_read_mux #(
      .IDX_W        (IDX_W),
      .DATA_W       (DATA_W),
      .CNT_W        (CNT_W),
      .HI_FILL_ONES (HI_FILL_ONES)
   ) i_read_mux (
      .clk        (clk),
      .rst_n      (rst_n),
      .op         (op),
      .cur_idx    (cur_idx),
      .ifsts      (ifsts),
      .byte_cnt   (byte_cnt),
      .dec_status (dec_status),
      .rdata      (rdata)
   );

   assign irq_pend = ~ifsts[1:0] & ifctl[1:0];
endmodule

// File: rtl/cdc_regport_chk.sv
module cdc_regport_chk #(
   parameter int IDX_W     = 5,
   parameter int DATA_W    = 8,
   parameter int CNT_W     = 12,
   parameter int DECEN_BIT = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              idx_we,
   input logic              dat_we,
   input logic              dat_re,
   input logic [DATA_W-1:0] host_wdata,
   input logic [IDX_W-1:0]  cur_idx,
   input logic [DATA_W-1:0] rdata,
   input logic [DATA_W-1:0] ifsts,
   input logic [CNT_W-1:0]  byte_cnt
);
   logic do_wr;
   logic do_rd;
   assign do_wr = !idx_we && dat_we;
   assign do_rd = !idx_we && !dat_we && dat_re;

   // R2
   a_r2_idx_load: assert property (@(posedge clk) disable iff (!rst_n)
      idx_we |=> (cur_idx == $past(host_wdata[IDX_W-1:0])));

   // R3
   a_r3_zero_stays: assert property (@(posedge clk) disable iff (!rst_n)
      ((do_wr || do_rd) && cur_idx == '0) |=> (cur_idx == '0));

   // R5
   a_r5_cnt_high: assert property (@(posedge clk) disable iff (!rst_n)
      (do_wr && cur_idx == IDX_W'(3)) |=>
      (byte_cnt[CNT_W-1:DATA_W] == $past(host_wdata[CNT_W-DATA_W-1:0]) && cur_idx == IDX_W'(4)));

   // R6
   a_r6_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (do_wr && cur_idx == IDX_W'(15)) |=>
      (cur_idx == IDX_W'(16) && ifsts == '1 && byte_cnt == '0));

   // R7
   a_r7_last_status: assert property (@(posedge clk) disable iff (!rst_n)
      (do_rd && cur_idx == IDX_W'(15)) |=> (cur_idx == IDX_W'(16)));

   // R8
   a_r8_unmapped_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (do_rd && cur_idx >= IDX_W'(16)) |=> (rdata == '1));

   // R9
   a_r9_decode_off: assert property (@(posedge clk) disable iff (!rst_n)
      (do_wr && cur_idx == IDX_W'(10) && !host_wdata[DECEN_BIT]) |=> ifsts[0]);

   // R10
   a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !do_rd |=> $stable(rdata));
endmodule

bind cdc_regport cdc_regport_chk #(
   .IDX_W     (IDX_W),
   .DATA_W    (DATA_W),
   .CNT_W     (CNT_W),
   .DECEN_BIT (DECEN_BIT)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .idx_we     (idx_we),
   .dat_we     (dat_we),
   .dat_re     (dat_re),
   .host_wdata (host_wdata),
   .cur_idx    (cur_idx),
   .rdata      (rdata),
   .ifsts      (ifsts),
   .byte_cnt   (byte_cnt)
);

// File: tb/test_cdc_regport.sv
`timescale 1ns/1ps
module test_cdc_regport;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        idx_we = 1'b0;
   logic        dat_we = 1'b0;
   logic        dat_re = 1'b0;
   logic [7:0]  host_wdata = '0;
   logic [31:0] dec_status = '0;
   logic        ev_decode = 1'b0;
   logic        ev_xfer_end = 1'b0;
   logic [7:0]  rdata;
   logic [4:0]  cur_idx;
   logic [7:0]  ifctl;
   logic [7:0]  ifsts;
   logic [11:0] byte_cnt;
   logic [87:0] cfg_regs;
   logic [1:0]  irq_pend;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic re_q = 1'b0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #4 clk = ~clk;

   cdc_regport i_cdc_regport (
      .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .dat_we(dat_we), .dat_re(dat_re),
      .host_wdata(host_wdata), .dec_status(dec_status), .ev_decode(ev_decode),
      .ev_xfer_end(ev_xfer_end), .rdata(rdata), .cur_idx(cur_idx), .ifctl(ifctl),
      .ifsts(ifsts), .byte_cnt(byte_cnt), .cfg_regs(cfg_regs), .irq_pend(irq_pend)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   // monitor: read data appears the cycle after the strobe
   always @(posedge clk) re_q <= dat_re & ~idx_we & ~dat_we;

   always @(negedge clk) begin
      if (re_q) begin
         if (exp_q.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL R10: unexpected read result %0h expected none", rdata);
         end else begin
            chk(tag_q.pop_front(), {24'h0, rdata}, {24'h0, exp_q.pop_front()});
         end
      end
   end

   task automatic set_idx(logic [7:0] v);
      @(negedge clk);
      idx_we = 1'b1; host_wdata = v;
      @(negedge clk);
      idx_we = 1'b0;
   endtask

   task automatic wr(logic [7:0] v);
      @(negedge clk);
      dat_we = 1'b1; host_wdata = v;
      @(negedge clk);
      dat_we = 1'b0;
   endtask

   task automatic rd(logic [7:0] exp, string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      dat_re = 1'b1;
      @(negedge clk);
      dat_re = 1'b0;
   endtask

   task automatic pulse_dec(bit which);
      @(negedge clk);
      if (which) ev_xfer_end = 1'b1; else ev_decode = 1'b1;
      @(negedge clk);
      ev_xfer_end = 1'b0; ev_decode = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 idx", cur_idx, 0);
      chk("R1 ifsts", ifsts, 8'hFF);
      chk("R1 ifctl", ifctl, 0);
      chk("R1 byte_cnt", byte_cnt, 0);
      chk("R1 cfg", {31'h0, (cfg_regs == '0)}, 1);
      chk("R1 rdata", rdata, 8'hFF);
      chk("R1 irq", irq_pend, 0);

      // R3 index 0 dead slot
      wr(8'h55);
      chk("R3 idx after write", cur_idx, 0);
      chk("R3 ifctl untouched", ifctl, 0);
      chk("R3 cfg untouched", {31'h0, (cfg_regs == '0)}, 1);
      rd(8'hFF, "R3 read idx0");
      chk("R3 idx after read", cur_idx, 0);

      // R2 index load keeps low 5 bits
      set_idx(8'hE1);
      chk("R2 idx load", cur_idx, 5'h01);
      // R11 control write
      wr(8'h03);
      chk("R11 ifctl", ifctl, 8'h03);
      chk("R11 idx", cur_idx, 2);
      // R5 byte counter
      wr(8'h34);
      chk("R5 idx after low", cur_idx, 3);
      wr(8'hA7);
      chk("R5 byte_cnt", byte_cnt, 12'h734);
      chk("R5 idx after high", cur_idx, 4);
      set_idx(8'h02);
      rd(8'h34, "R5 read low");
      chk("R5 idx after low read", cur_idx, 3);
      rd(8'hF7, "R5 read high");
      chk("R5 idx after high read", cur_idx, 4);

      // R11 configuration slots
      wr(8'h11);
      chk("R11 cfg slot0", cfg_regs[7:0], 8'h11);
      chk("R11 idx", cur_idx, 5);
      set_idx(8'h0E);
      wr(8'h22);
      chk("R11 cfg slot10", cfg_regs[87:80], 8'h22);
      chk("R8 idx after plain write", cur_idx, 5'h0F);

      // R4 status events, R11 pending flags
      pulse_dec(1'b0);
      chk("R4 decode pending", ifsts, 8'hFE);
      chk("R11 irq dec", irq_pend, 2'b01);
      pulse_dec(1'b1);
      chk("R4 xfer pending", ifsts, 8'hFC);
      chk("R11 irq both", irq_pend, 2'b11);
      set_idx(8'h01);
      rd(8'hFC, "R4 read status");
      chk("R4 idx after status read", cur_idx, 2);

      // R9 decode enable
      set_idx(8'h0A);
      wr(8'h80);
      chk("R9 enabled keeps pending", ifsts, 8'hFC);
      chk("R11 cfg slot6", cfg_regs[55:48], 8'h80);
      set_idx(8'h0A);
      wr(8'h00);
      chk("R9 disabled clears pending", ifsts, 8'hFD);
      chk("R9 idx", cur_idx, 5'h0B);

      // R12 write beats read, disable beats event
      set_idx(8'h0A);
      @(negedge clk);
      dat_we = 1'b1; dat_re = 1'b1; ev_decode = 1'b1; host_wdata = 8'h00;
      @(negedge clk);
      dat_we = 1'b0; dat_re = 1'b0; ev_decode = 1'b0;
      chk("R12 disable wins", ifsts[0], 1);
      chk("R12 write taken", cfg_regs[55:48], 8'h00);
      chk("R12 rdata no read", rdata, 8'hFC);

      // R7 decoder status bytes
      dec_status = 32'hD4C3B2A1;
      set_idx(8'h0C);
      rd(8'hA1, "R7 status0");
      rd(8'hB2, "R7 status1");
      rd(8'hC3, "R7 status2");
      chk("R7 idx", cur_idx, 5'h0F);
      rd(8'hD4, "R7 status3");
      chk("R7 park", cur_idx, 5'h10);

      // R10 hold while no read
      wr(8'h77);
      chk("R10 rdata held", rdata, 8'hD4);
      chk("R8 idx 0x10 write", cur_idx, 5'h11);

      // R8 unmapped reads and wrap
      rd(8'hFF, "R8 read 0x11");
      chk("R8 idx", cur_idx, 5'h12);
      set_idx(8'h1F);
      rd(8'hFF, "R8 read 0x1F");
      chk("R8 wrap", cur_idx, 0);
      set_idx(8'h05);
      rd(8'hFF, "R8 read config slot");
      chk("R8 idx", cur_idx, 6);

      // R6 soft reset
      set_idx(8'h0F);
      wr(8'h99);
      chk("R6 idx", cur_idx, 5'h10);
      chk("R6 ifsts", ifsts, 8'hFF);
      chk("R6 ifctl", ifctl, 0);
      chk("R6 byte_cnt", byte_cnt, 0);
      chk("R6 cfg", {31'h0, (cfg_regs == '0)}, 1);
      chk("R6 irq", irq_pend, 0);

      @(negedge clk);
      chk("R10 queue drained", exp_q.size(), 0);
      finish_run();
   end
endmodule